// File: doc/BRIEF.md
# GPIO Port Data Register Bank

This block holds the data side of a 32-pin general-purpose I/O port. It keeps an output latch and a per-pin direction register, and it brings the external pin levels into the clock domain through a synchroniser. Software reaches it over a simple word-addressed register interface with an address, a write strobe, write data and combinational read data. Pins appear as three separate vectors: the driven value, the output enable and the sampled input.

Besides a plain data-output register that replaces the whole latch, three write-only command registers change chosen latch bits without a read-modify-write. One register forces bits to 1, one forces bits to 0, and one inverts them. In each of them, a 1 in the written word selects a pin and a 0 leaves that pin alone. All register updates take effect at the rising clock edge on which `wr_en` is high. Read data follows `addr` combinationally.

There is no state machine. The register selects form one enumerated set: `SEL_NONE`, `SEL_DATA`, `SEL_SET`, `SEL_CLR`, `SEL_TGL`, `SEL_PIN` and `SEL_DIR`. The address decode produces exactly one of them each cycle, and both the latch update and the read multiplexer branch on it.

Top module: `gpio_data_bank`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero, so every pin is an input and drives 0.
- R2: A write to offset 0x00 replaces the whole output latch with `wdata`. Reading 0x00 returns the latch, and `pin_out` always equals the latch.
- R3: A write to offset 0x04 sets every latch bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears every latch bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R7: A write to offset 0x14 loads the direction register, where bit value 1 means output and 0 means input. Reading 0x14 returns it, and `pin_oe` equals it.
- R8: Reading offset 0x10 returns `pin_in` delayed by two flops. A change becomes visible after the second rising edge that follows it. Writes to 0x10 change neither the latch nor the direction register.
- R9: Any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 reads zero. This includes addresses that are not multiples of 4. A write to such an offset leaves the latch and the direction register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte offset of the register |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Output enable per pin, 1 means drive |

## Verification
The output latch and the direction register drive `pin_out` and `pin_oe` directly. A wrong bit produced by a set, clear, toggle or plain write therefore shows at the ports one edge after the write, and stays there until another write repairs it. A decode fault shows in two ways: a read of an unmapped or write-only offset returns non-zero data, or a stray write disturbs `pin_out` or `pin_oe` on the next cycle. A wrong synchroniser depth shows as data-input reads that change one edge too early or one edge too late relative to the pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_SET  = 'h04;
    localparam int OFS_CLR  = 'h08;
    localparam int OFS_TGL  = 'h0C;
    localparam int OFS_PIN  = 'h10;
    localparam int OFS_DIR  = 'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_SET,
        SEL_CLR,
        SEL_TGL,
        SEL_PIN,
        SEL_DIR
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if      (addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
        else if (addr == ADDR_W'(OFS_SET))  sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_CLR))  sel = SEL_CLR;
        else if (addr == ADDR_W'(OFS_TGL))  sel = SEL_TGL;
        else if (addr == ADDR_W'(OFS_PIN))  sel = SEL_PIN;
        else if (addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
        else                                sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] dir_q
);

    logic [PINS-1:0] latch_d;
    logic [PINS-1:0] dir_d;

    always_comb begin
        latch_d = latch_q;
        dir_d   = dir_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA: latch_d = wdata;
                SEL_SET:  latch_d = latch_q | wdata;
                SEL_CLR:  latch_d = latch_q & ~wdata;
                SEL_TGL:  latch_d = latch_q ^ wdata;
                SEL_DIR:  dir_d   = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            dir_q   <= dir_d;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PINS   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] raw_in,
    output logic [PINS-1:0] sync_out
);

    logic [PINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    reg_sel_e        sel;
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] pin_sync;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    gpio_out_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_data = latch_q;
            SEL_PIN:  rd_data = pin_sync;
            SEL_DIR:  rd_data = dir_q;
            default:  rd_data = '0;
        endcase
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_data_bank_chk.sv
module gpio_data_bank_chk #(
    parameter int PINS   = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [PINS-1:0]   wdata,
    input logic [PINS-1:0]   rd_data,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);

    logic wr_data, wr_set, wr_clr, wr_tgl, wr_dir, wr_other;
    logic rd_cmd;

    assign wr_data  = wr_en && addr == ADDR_W'('h00);
    assign wr_set   = wr_en && addr == ADDR_W'('h04);
    assign wr_clr   = wr_en && addr == ADDR_W'('h08);
    assign wr_tgl   = wr_en && addr == ADDR_W'('h0C);
    assign wr_dir   = wr_en && addr == ADDR_W'('h14);
    assign wr_other = wr_en && !(addr == ADDR_W'('h00) || addr == ADDR_W'('h04) ||
                                 addr == ADDR_W'('h08) || addr == ADDR_W'('h0C) ||
                                 addr == ADDR_W'('h14));
    assign rd_cmd   = addr == ADDR_W'('h04) || addr == ADDR_W'('h08) ||
                      addr == ADDR_W'('h0C);

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> pin_out == $past(wdata));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pin_out == ($past(pin_out) | $past(wdata)));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pin_out == ($past(pin_out) & ~$past(wdata)));

    assert_toggle_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tgl |=> pin_out == ($past(pin_out) ^ $past(wdata)));

    assert_cmd_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |-> rd_data == '0);

    assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(wdata));

    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

    assert_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_other |=> $stable(pin_out) && $stable(pin_oe));

endmodule

bind gpio_data_bank gpio_data_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpio_data_bank_tb_top.sv
module gpio_data_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    gpio_data_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic pins_check(input string tag);
        check({tag, " pin_out"}, pin_out, m_out);
        check({tag, " pin_oe"}, pin_oe, m_dir);
        rd_check({tag, " rd data"}, 8'h00, m_out);
        rd_check({tag, " rd dir"}, 8'h14, m_dir);
    endtask

    initial begin
        #4_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        pins_check("R1");

        // R2: walking-one and random plain writes
        for (int i = 0; i < 32; i++) begin
            m_out = 32'h1 << i;
            wr(8'h00, m_out);
            pins_check("R2 walk");
        end
        for (int i = 0; i < 16; i++) begin
            lfsr = next_rand(lfsr);
            m_out = lfsr;
            wr(8'h00, m_out);
            pins_check("R2 rand");
        end

        // R3, R4, R5: per-bit and random command writes
        wr(8'h00, 32'h0); m_out = 32'h0;
        for (int i = 0; i < 32; i++) begin
            wr(8'h04, 32'h1 << i); m_out |= 32'h1 << i;
            pins_check("R3 set bit");
        end
        for (int i = 0; i < 32; i += 2) begin
            wr(8'h08, 32'h1 << i); m_out &= ~(32'h1 << i);
            pins_check("R4 clear bit");
        end
        for (int i = 0; i < 32; i += 3) begin
            wr(8'h0C, 32'h1 << i); m_out ^= 32'h1 << i;
            pins_check("R5 toggle bit");
        end
        for (int i = 0; i < 24; i++) begin
            lfsr = next_rand(lfsr);
            case (i % 3)
                0: begin wr(8'h04, lfsr); m_out |= lfsr;  pins_check("R3 set rand"); end
                1: begin wr(8'h08, lfsr); m_out &= ~lfsr; pins_check("R4 clear rand"); end
                default: begin wr(8'h0C, lfsr); m_out ^= lfsr; pins_check("R5 toggle rand"); end
            endcase
        end
        wr(8'h04, 32'h0); pins_check("R3 zero mask");
        wr(8'h08, 32'h0); pins_check("R4 zero mask");
        wr(8'h0C, 32'h0); pins_check("R5 zero mask");
        wr(8'h0C, 32'hFFFF_FFFF); m_out = ~m_out; pins_check("R5 full mask");

        // R6: command registers read zero
        rd_check("R6 set reads zero", 8'h04, 32'h0);
        rd_check("R6 clear reads zero", 8'h08, 32'h0);
        rd_check("R6 toggle reads zero", 8'h0C, 32'h0);

        // R7: direction register
        for (int i = 0; i < 12; i++) begin
            lfsr = next_rand(lfsr);
            m_dir = lfsr;
            wr(8'h14, m_dir);
            pins_check("R7 dir");
        end

        // R8: two-flop input delay, write ignored
        for (int i = 0; i < 10; i++) begin
            logic [31:0] old_v;
            old_v = pin_in;
            lfsr = next_rand(lfsr);
            @(negedge clk);
            pin_in = lfsr;
            rd_check("R8 before edge", 8'h10, old_v);
            @(negedge clk);
            rd_check("R8 after one edge", 8'h10, old_v);
            @(negedge clk);
            rd_check("R8 after two edges", 8'h10, lfsr);
        end
        wr(8'h10, ~m_out);
        pins_check("R8 write ignored");
        rd_check("R8 input after write", 8'h10, pin_in);

        // R9: sweep every address
        for (int a = 0; a < 256; a++) begin
            logic [31:0] exp_rd;
            case (a)
                'h00: exp_rd = m_out;
                'h10: exp_rd = pin_in;
                'h14: exp_rd = m_dir;
                default: exp_rd = 32'h0;
            endcase
            rd_check("R9 read sweep", 8'(a), exp_rd);
            if (!(a == 'h00 || a == 'h04 || a == 'h08 || a == 'h0C || a == 'h10 || a == 'h14)) begin
                wr(8'(a), 32'hFFFF_FFFF);
                check("R9 stray write pin_out", pin_out, m_out);
                check("R9 stray write pin_oe", pin_oe, m_dir);
            end
        end

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_out = '0; m_dir = '0;
        check("R1 reapplied pin_out", pin_out, 32'h0);
        check("R1 reapplied pin_oe", pin_oe, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule